// File: doc/BRIEF.md
# Eight-Line Rotating-Priority Interrupt Controller

The block collects eight interrupt request lines and presents one interrupt output to a processor. Each line is captured into a pending-request register. A line is captured either on a rising edge or as a plain level, chosen per line. Pending requests pass through a mask register and then a priority resolver. The resolver picks the most urgent pending level that is not held off by a level already being serviced.

When a winner exists and the controller is enabled, the interrupt output goes high. The processor answers with two acknowledge pulses:

- The first pulse commits the winner to the in-service register and consumes its edge-captured request.
- The second pulse makes the block present an 8-bit vector for one cycle. The vector is a programmable base in the upper five bits and the level number in the lower three bits.

If nothing valid is pending at the first pulse, the vector carries level 7 and no level enters service.

Priority is held as a pointer to the lowest-priority level, and the other levels follow it in circular order. At reset level 7 is lowest, so level 0 is most urgent. Software can name the lowest level directly. In automatic mode, the level retired by a non-specific end-of-interrupt becomes lowest. End-of-interrupt commands retire in-service levels, either the most urgent one or a named one.

Configuration uses a single write port with these addresses:

| Address | Contents |
|---|---|
| 0 | Control: bit 0 enable, bit 1 automatic rotation |
| 1 | Trigger select: bit i = 1 makes line i level-triggered |
| 2 | Mask |
| 3 | Vector base, in data bits 7:3 |
| 4 | Command: opcode in bits 7:5, level in bits 2:0 |

Command opcodes:

| Opcode | Action |
|---|---|
| 001 | Non-specific end-of-interrupt |
| 011 | Specific end-of-interrupt for the named level |
| 110 | Name the lowest-priority level |

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, int_out, vec_valid and vec_out are all 0, the controller is disabled, all lines are edge-triggered, nothing is masked, and level 7 is lowest priority.
- R2: On an edge-triggered line, a 0-to-1 transition records a request that stays pending after the line falls. A line that stays high after its request was acknowledged raises no new request until it falls and rises again.
- R3: On a level-triggered line (trigger bit = 1), the pending request follows the line one clock later. It is not consumed by an acknowledge, so it requests again after its end-of-interrupt while the line stays high.
- R4: A mask bit of 1 keeps that level out of arbitration without discarding its pending request. Clearing the mask bit lets the level win again.
- R5: With the reset priority order, the lowest-numbered pending level wins.
- R6: A level in service blocks requests of equal and lower priority, while a strictly higher-priority request still raises int_out (nesting).
- R7: The first acknowledge pulse commits the winner. After the second pulse, vec_valid is 1 for exactly one cycle, with vec_out = {base[7:3], level}.
- R8: A non-specific end-of-interrupt (command opcode 001) clears only the in-service bit of the most urgent level in service.
- R9: A specific end-of-interrupt (command opcode 011, level in bits 2:0) clears the in-service bit of the named level.
- R10: In automatic mode (control bit 1), the level retired by a non-specific end-of-interrupt becomes the lowest priority.
- R11: The set-lowest command (opcode 110, level in bits 2:0) makes the named level lowest and the next level circularly highest.
- R12: While the enable bit (control bit 0) is 0, int_out stays 0 whatever is pending.
- R13: A first acknowledge with no valid winner is spurious. It yields vector level 7 and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Interrupt request lines, synchronous to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_ack | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector present on vec_out this cycle |
| vec_out | output | 8 | Interrupt vector, zero when not valid |

## Verification
The assertions take for granted the following about the inputs:

- cpu_ack arrives as single-cycle pulses in pairs.
- irq_in and the configuration port are synchronous to clk.
- A set-lowest command never shares a cycle with an end-of-interrupt.

The stimulus keeps to this. Every acknowledge is issued as two separated one-cycle pulses, and all inputs change on the falling clock edge. Random request patterns are dropped back to zero after one cycle, so that every random request is a fresh edge.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
  localparam int unsigned IRQ_N = 8;
  localparam int unsigned LVL_W = $clog2(IRQ_N);
  localparam int unsigned ADR_W = 3;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [IRQ_N-1:0] irq_vec_t;

  localparam logic [ADR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADR_W-1:0] A_TRIG = 3'd1;
  localparam logic [ADR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADR_W-1:0] A_BASE = 3'd3;
  localparam logic [ADR_W-1:0] A_CMD  = 3'd4;

  typedef enum logic [2:0] {
    OP_NOP     = 3'b000,
    OP_EOI_TOP = 3'b001,
    OP_EOI_LVL = 3'b011,
    OP_SET_LOW = 3'b110
  } cmd_op_e;

  typedef enum logic [0:0] {
    ACK_IDLE  = 1'b0,
    ACK_WAIT2 = 1'b1
  } ack_st_e;

  typedef struct packed {
    logic hit;
    lvl_t lvl;
  } pick_t;

  // Rank 0 is most urgent: the level right after the lowest-priority one.
  function automatic lvl_t prio_rank(lvl_t lvl, lvl_t low);
    return lvl_t'(lvl - low - lvl_t'(1));
  endfunction

  // Most urgent set bit of v under the circular order fixed by low.
  function automatic pick_t pick_top(irq_vec_t v, lvl_t low);
    pick_t p;
    p = '0;
    for (int r = IRQ_N - 1; r >= 0; r--) begin
      lvl_t l;
      l = lvl_t'(low + lvl_t'(r) + lvl_t'(1));
      if (v[l]) begin
        p.hit = 1'b1;
        p.lvl = l;
      end
    end
    return p;
  endfunction

  function automatic irq_vec_t lvl_onehot(lvl_t l);
    return irq_vec_t'(1) << l;
  endfunction
endpackage

// File: rtl/irq_req_capture.sv
`timescale 1ns/1ps
module irq_req_capture
  import irq_prio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t irq_in,
  input  irq_vec_t trig_lvl,
  input  irq_vec_t consume,
  output irq_vec_t irr
);
  irq_vec_t prev_q;
  irq_vec_t rise_ev;

  assign rise_ev = irq_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  for (genvar i = 0; i < IRQ_N; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irr[i] <= 1'b0;
      end else if (trig_lvl[i]) begin
        irr[i] <= irq_in[i];
      end else if (rise_ev[i]) begin
        irr[i] <= 1'b1;
      end else if (consume[i]) begin
        irr[i] <= 1'b0;
      end
    end

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_ev[i] && !trig_lvl[i]) |=> irr[i]); // R2
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      trig_lvl[i] |=> (irr[i] == $past(irq_in[i]))); // R3
  end
endmodule

// File: rtl/irq_prio_resolver.sv
`timescale 1ns/1ps
module irq_prio_resolver
  import irq_prio_pkg::*;
(
  input  irq_vec_t irr,
  input  irq_vec_t mask,
  input  irq_vec_t isr,
  input  lvl_t     low,
  output logic     win_hit,
  output lvl_t     win_lvl
);
  irq_vec_t pend;
  pick_t    req_top;
  pick_t    svc_top;

  assign pend    = irr & ~mask;
  assign req_top = pick_top(pend, low);
  assign svc_top = pick_top(isr, low);

  always_comb begin
    win_lvl = req_top.lvl;
    if (!req_top.hit)      win_hit = 1'b0;
    else if (!svc_top.hit) win_hit = 1'b1;
    else win_hit = (prio_rank(req_top.lvl, low) < prio_rank(svc_top.lvl, low));
  end
endmodule

// File: rtl/irq_insvc.sv
`timescale 1ns/1ps
module irq_insvc
  import irq_prio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t set_vec,
  input  logic     eoi_top,
  input  logic     eoi_named,
  input  lvl_t     eoi_lvl,
  input  lvl_t     low,
  output irq_vec_t isr,
  output logic     top_done,
  output lvl_t     top_lvl
);
  pick_t    svc_top;
  irq_vec_t clr_vec;

  assign svc_top  = pick_top(isr, low);
  assign top_done = eoi_top && svc_top.hit;
  assign top_lvl  = svc_top.lvl;

  always_comb begin
    clr_vec = '0;
    if (top_done)  clr_vec = clr_vec | lvl_onehot(svc_top.lvl);
    if (eoi_named) clr_vec = clr_vec | lvl_onehot(eoi_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~clr_vec) | set_vec;
  end

  AST_SET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec)); // R7
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec != '0) && (set_vec == '0)) |=> ((isr & $past(clr_vec)) == '0)); // R8
  AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_top && !eoi_named && (set_vec == '0)) |=> ($countones($past(isr) & ~isr) <= 1)); // R8
endmodule

// File: rtl/irq_prio_order.sv
`timescale 1ns/1ps
module irq_prio_order
  import irq_prio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_low,
  input  lvl_t set_lvl,
  input  logic auto_en,
  input  logic done_ev,
  input  lvl_t done_lvl,
  output lvl_t low
);
  logic auto_ev;
  assign auto_ev = auto_en && done_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low <= lvl_t'(IRQ_N - 1);
    else if (set_low) low <= set_lvl;
    else if (auto_ev) low <= done_lvl;
  end

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_low && !auto_ev) |=> $stable(low)); // R11
  AST_AUTO_ROT: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_ev && !set_low) |=> (low == $past(done_lvl))); // R10
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned CFG_W = 8,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] irq_in,
  input  logic             cfg_we,
  input  logic [ADR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cpu_ack,
  output logic             int_out,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out
);
  localparam int unsigned BASE_W = VEC_W - LVL_W;

  // configuration state
  logic              en_q;
  logic              auto_q;
  irq_vec_t          trig_q;
  irq_vec_t          mask_q;
  logic [BASE_W-1:0] base_q;

  // command decode
  logic    cmd_we;
  cmd_op_e cmd_op;
  lvl_t    cmd_lvl;
  logic    eoi_top;
  logic    eoi_named;
  logic    set_low;

  // internal events brought out for checking
  irq_vec_t irr;
  irq_vec_t isr;
  lvl_t     low;
  logic     win_hit;
  lvl_t     win_lvl;
  logic     int_raise;
  logic     ack1_ev;
  logic     ack_take;
  logic     spurious_ev;
  logic     ack2_ev;
  irq_vec_t set_vec;
  irq_vec_t consume;
  logic     top_done;
  lvl_t     top_lvl;
  ack_st_e  st_q;
  lvl_t     held_q;

  assign cmd_we    = cfg_we && (cfg_addr == A_CMD);
  assign cmd_op    = cmd_op_e'(cfg_wdata[7:5]);
  assign cmd_lvl   = cfg_wdata[LVL_W-1:0];
  assign eoi_top   = cmd_we && (cmd_op == OP_EOI_TOP);
  assign eoi_named = cmd_we && (cmd_op == OP_EOI_LVL);
  assign set_low   = cmd_we && (cmd_op == OP_SET_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      trig_q <= '0;
      mask_q <= '0;
      base_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_CTRL: begin
          en_q   <= cfg_wdata[0];
          auto_q <= cfg_wdata[1];
        end
        A_TRIG:  trig_q <= cfg_wdata[IRQ_N-1:0];
        A_MASK:  mask_q <= cfg_wdata[IRQ_N-1:0];
        A_BASE:  base_q <= cfg_wdata[VEC_W-1:LVL_W];
        default: ;
      endcase
    end
  end

  irq_req_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .trig_lvl(trig_q),
    .consume (consume),
    .irr     (irr)
  );

  irq_prio_resolver u_res (
    .irr    (irr),
    .mask   (mask_q),
    .isr    (isr),
    .low    (low),
    .win_hit(win_hit),
    .win_lvl(win_lvl)
  );

  irq_insvc u_isr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .eoi_top  (eoi_top),
    .eoi_named(eoi_named),
    .eoi_lvl  (cmd_lvl),
    .low      (low),
    .isr      (isr),
    .top_done (top_done),
    .top_lvl  (top_lvl)
  );

  irq_prio_order u_ord (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_low (set_low),
    .set_lvl (cmd_lvl),
    .auto_en (auto_q),
    .done_ev (top_done),
    .done_lvl(top_lvl),
    .low     (low)
  );

  // acknowledge handshake
  assign int_raise   = en_q && win_hit;
  assign int_out     = int_raise && (st_q == ACK_IDLE);
  assign ack1_ev     = cpu_ack && (st_q == ACK_IDLE);
  assign ack2_ev     = cpu_ack && (st_q == ACK_WAIT2);
  assign ack_take    = ack1_ev && int_raise;
  assign spurious_ev = ack1_ev && !int_raise;
  assign set_vec     = ack_take ? lvl_onehot(win_lvl) : '0;
  assign consume     = set_vec & ~trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ACK_IDLE;
      held_q    <= '0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      vec_valid <= 1'b0;
      vec_out   <= '0;
      if (ack1_ev) begin
        held_q <= int_raise ? win_lvl : lvl_t'(IRQ_N - 1);
        st_q   <= ACK_WAIT2;
      end else if (ack2_ev) begin
        vec_valid <= 1'b1;
        vec_out   <= {base_q, held_q};
        st_q      <= ACK_IDLE;
      end
    end
  end

  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid); // R7
  AST_VEC_AFTER_ACK2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(cpu_ack) && ($past(st_q) == ACK_WAIT2))); // R7
  AST_INT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !int_out); // R12
  AST_MASKED_NOT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |-> !mask_q[win_lvl]); // R4
  AST_SPUR_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (spurious_ev && !cmd_we) |=> $stable(isr)); // R13
  AST_NO_SELF_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |-> !isr[win_lvl]); // R6
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       cpu_ack = 1'b0;
  logic       int_out;
  logic       vec_valid;
  logic [7:0] vec_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cpu_ack(cpu_ack),
    .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  always #5 clk = ~clk;

  // bench-side model of the priority rules
  function automatic int b_rank(int lvl, int low);
    return (lvl + 7 - low) % 8;
  endfunction

  function automatic int b_top(logic [7:0] v, int low);
    for (int r = 0; r < 8; r++) begin
      if (v[(low + 1 + r) % 8]) return (low + 1 + r) % 8;
    end
    return -1;
  endfunction

  function automatic int b_winner(logic [7:0] pend, logic [7:0] svc, int low);
    int w;
    int s;
    w = b_top(pend, low);
    s = b_top(svc, low);
    if (w < 0) return -1;
    if (s >= 0 && b_rank(w, low) >= b_rank(s, low)) return -1;
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack_pair(output logic [7:0] v, output logic vv);
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
    vv = vec_valid;
    v  = vec_out;
  endtask

  task automatic ack_chk(string req, logic [7:0] exp);
    logic [7:0] v;
    logic vv;
    ack_pair(v, vv);
    chk(req, int'(vv), 1);
    chk(req, int'(v), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic vv;
    logic [7:0] m_irr;
    logic [7:0] m_isr;
    logic [7:0] m_mask;
    logic [7:0] nw;
    int m_low;
    bit m_auto;
    int w;
    int t;

    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 int_out", int'(int_out), 0);
    chk("R1 vec_valid", int'(vec_valid), 0);
    chk("R1 vec_out", int'(vec_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 int_out after release", int'(int_out), 0);

    // R12: disabled controller stays quiet
    drive(8'h04);
    chk("R12 disabled", int'(int_out), 0);
    wr(3'd3, 8'h40);
    wr(3'd0, 8'h01);
    chk("R2 edge kept", int'(int_out), 1);
    ack_chk("R7 vector", 8'h42);
    @(negedge clk);
    chk("R7 one cycle", int'(vec_valid), 0);
    chk("R7 vec cleared", int'(vec_out), 0);
    wr(3'd4, 8'h20);
    chk("R2 held high no rerequest", int'(int_out), 0);
    drive(8'h00);
    drive(8'h04);
    chk("R2 new edge", int'(int_out), 1);
    ack_chk("R2 vector", 8'h42);
    wr(3'd4, 8'h20);
    drive(8'h00);

    // R5/R6/R8/R9: fixed order, nesting, retiring
    drive(8'h28);
    ack_chk("R5 lowest number wins", 8'h43);
    chk("R6 lower blocked", int'(int_out), 0);
    drive(8'h2A);
    chk("R6 higher nests", int'(int_out), 1);
    ack_chk("R6 nested vector", 8'h41);
    wr(3'd4, 8'h20);
    chk("R8 only top cleared", int'(int_out), 0);
    wr(3'd4, 8'h63);
    chk("R9 named cleared", int'(int_out), 1);
    ack_chk("R9 vector", 8'h45);
    wr(3'd4, 8'h20);
    drive(8'h00);

    // R4: masking keeps the request
    wr(3'd2, 8'h10);
    drive(8'h10);
    chk("R4 masked", int'(int_out), 0);
    wr(3'd2, 8'h00);
    chk("R4 unmasked", int'(int_out), 1);
    ack_chk("R4 vector", 8'h44);
    wr(3'd4, 8'h20);
    drive(8'h00);

    // R11: level 2 lowest, level 3 highest
    wr(3'd4, 8'hC2);
    drive(8'h0C);
    ack_chk("R11 three first", 8'h43);
    wr(3'd4, 8'h20);
    ack_chk("R11 two last", 8'h42);
    wr(3'd4, 8'h20);
    wr(3'd4, 8'hC7);
    drive(8'h00);

    // R10: automatic rotation
    wr(3'd0, 8'h03);
    drive(8'h01);
    ack_chk("R10 level0", 8'h40);
    wr(3'd4, 8'h20);
    drive(8'h00);
    drive(8'h81);
    ack_chk("R10 rotated order", 8'h47);
    wr(3'd4, 8'h20);
    ack_chk("R10 level0 after", 8'h40);
    wr(3'd4, 8'h20);
    wr(3'd0, 8'h01);
    wr(3'd4, 8'hC7);
    drive(8'h00);

    // R3: level-triggered line 4
    wr(3'd1, 8'h10);
    drive(8'h10);
    chk("R3 level request", int'(int_out), 1);
    ack_chk("R3 vector", 8'h44);
    wr(3'd4, 8'h20);
    chk("R3 re-request while high", int'(int_out), 1);
    drive(8'h00);
    chk("R3 request follows line", int'(int_out), 0);

    // R13: spurious acknowledge
    drive(8'h10);
    chk("R13 setup", int'(int_out), 1);
    drive(8'h00);
    ack_chk("R13 spurious vector", 8'h47);
    wr(3'd1, 8'h00);
    drive(8'h80);
    chk("R13 no level in service", int'(int_out), 1);
    ack_chk("R13 real level7", 8'h47);
    wr(3'd4, 8'h20);
    drive(8'h00);

    // constrained random, edge mode, model-checked
    m_irr = '0; m_isr = '0; m_mask = '0; m_low = 7; m_auto = 1'b0;
    for (int it = 0; it < 400; it++) begin
      if (it == 200) begin
        m_auto = 1'b1;
        wr(3'd0, 8'h03);
      end
      nw = 8'($urandom) & 8'($urandom);
      drive(nw);
      irq_in = 8'h00;
      m_irr = m_irr | nw;
      if ($urandom % 4 == 0) begin
        m_mask = 8'($urandom) & 8'($urandom);
        wr(3'd2, m_mask);
      end
      w = b_winner(m_irr & ~m_mask, m_isr, m_low);
      chk("R6 random int_out", int'(int_out), (w >= 0) ? 1 : 0);
      if (w >= 0) begin
        ack_chk("R7 random vector", 8'h40 | 8'(w));
        m_isr[w] = 1'b1;
        m_irr[w] = 1'b0;
      end
      if (m_isr != 0 && ($urandom % 2 == 0)) begin
        t = b_top(m_isr, m_low);
        wr(3'd4, 8'h20);
        m_isr[t] = 1'b0;
        if (m_auto) m_low = t;
      end
      if ($urandom % 8 == 0) begin
        t = int'($urandom % 8);
        wr(3'd4, 8'hC0 | 8'(t));
        m_low = t;
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule